// File: doc/BRIEF.md
# Write-Unlock Command Sequence Detector

This block guards a non-volatile memory's page buffer against stray writes. It sits between the byte-capture logic and the page load controller. Each byte write that the capture logic latches shows up as a one-cycle load strobe, together with its address and data. The detector lets a byte through to the page buffer only after a three-write key has been seen. The key is data AA at address 5555h, then data 55 at 2AAAh, then data A0 at 5555h. The key writes are subject to the same byte-to-byte window as page loads. The load controller signals the end of that window with a one-cycle expiry pulse. The key bytes themselves are never committed.

A write that does not follow the key is treated as an unprotected data write. The load controller still runs the window and starts a full programming cycle, but the detector commits nothing. Protection is one-shot: when the programming cycle ends, the controller pulses a done input and the detector re-arms. The next load then needs the whole key again.

The controller has six states:
- `ST_ARMED`: waiting for the first key write.
- `ST_KEY1`: the first key write has been seen.
- `ST_KEY2`: the second key write has been seen.
- `ST_OPEN`: writes are unlocked and data bytes are being loaded.
- `ST_STRAY`: an unprotected write has been taken and nothing will be stored.
- `ST_PROG`: the detector waits for the programming cycle to finish.

Its transitions are:
- `key_hit`: ARMED to KEY1, KEY1 to KEY2, and KEY2 to OPEN.
- `key_miss`: a mismatching strobe from any of ARMED, KEY1 or KEY2 goes to STRAY.
- `key_timeout`: expiry in KEY1 or KEY2 goes back to ARMED. A strobe in that same cycle is then judged as a first key write.
- `window_close`: expiry in OPEN or STRAY goes to PROG.
- `prog_end`: done in PROG goes to ARMED.

Top module: `wr_unlock_det`

## Requirements
- R1: While reset is held and in the first cycle after it, `unlocked` and `commit_en` are 0 and the detector is in ARMED.
- R2: Strobes of (5555h, AAh), (2AAAh, 55h) and (5555h, A0h), each arriving before an expiry pulse, set `unlocked` to 1 from the cycle after the third strobe. `commit_en` stays 0 for all three key strobes.
- R3: While unlocked, the page is address bits [14:6] and the offset is bits [5:0]. The first data strobe fixes the page, and `commit_en` is 1 in the same cycle as that strobe. Later strobes that carry the same page also give 1, in any offset order, including rewrites. Strobes on another page give 0.
- R4: A wrong address or data value at any key step does not unlock. That strobe and every strobe after it give `commit_en` = 0 until a done pulse.
- R5: An expiry pulse in KEY1 or KEY2 returns the detector to its first step. A strobe in the same cycle as that pulse is judged as a first key write.
- R6: An expiry pulse in OPEN or STRAY clears `unlocked` in the next cycle and the detector waits for done. An expiry that coincides with a strobe in OPEN gives `commit_en` = 0. Strobes received while waiting give 0.
- R7: A done pulse while waiting re-arms the detector, so a plain write after it gives `commit_en` = 0 and the full key is needed again.
- R8: While unlocked, the key addresses are ordinary locations: a strobe to 5555h with data AAh on the fixed page gives `commit_en` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | One-cycle strobe for a captured byte write |
| ld_addr | input | 15 | Captured byte address |
| ld_data | input | 8 | Captured byte data |
| win_expire | input | 1 | One-cycle pulse: the byte-to-byte window has run out |
| prog_done | input | 1 | One-cycle pulse: the programming cycle has finished |
| unlocked | output | 1 | The key has been seen and the load window is open |
| commit_en | output | 1 | The byte strobed this cycle may be written to the page buffer (combinational) |

## Verification
A load strobe and a window-expiry pulse can arrive in the same cycle. The bench drives this coincidence in two states.

In KEY1, it drives a repeated first key write together with the expiry pulse. The detector must then accept the second and third key writes and commit the data byte that follows. A design that dropped the coinciding strobe would reject the second key write instead.

In OPEN, it drives an on-page data strobe together with the expiry pulse. That byte must not be committed, and `unlocked` must fall in the next cycle.

// File: rtl/wr_unlock_pkg.sv
package wr_unlock_pkg;

    typedef enum logic [2:0] {
        ST_ARMED = 3'd0,
        ST_KEY1  = 3'd1,
        ST_KEY2  = 3'd2,
        ST_OPEN  = 3'd3,
        ST_STRAY = 3'd4,
        ST_PROG  = 3'd5
    } ulk_state_t;

    localparam int unsigned NUM_KEYS = 3;

endpackage

// File: rtl/ulk_key_cmp.sv
module ulk_key_cmp #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned NKEY   = 3,
    parameter logic [NKEY*ADDR_W-1:0] KEY_ADDRS = '0,
    parameter logic [NKEY*DATA_W-1:0] KEY_DATAS = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic [NKEY-1:0]   hit
);

    // One comparator per key step; step k sits at slice k of each vector.
    for (genvar k = 0; k < NKEY; k++) begin : g_step
        assign hit[k] = (addr == KEY_ADDRS[k*ADDR_W +: ADDR_W]) &&
                        (data == KEY_DATAS[k*DATA_W +: DATA_W]);
    end

endmodule

// File: rtl/ulk_page_guard.sv
module ulk_page_guard #(
    parameter int unsigned PG_W = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            take,
    input  logic [PG_W-1:0] pg_in,
    output logic            in_page
);

    logic            held;
    logic [PG_W-1:0] pg_q;

    // The first accepted data byte fixes the page for the rest of the load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
            pg_q <= '0;
        end else if (clear) begin
            held <= 1'b0;
        end else if (take && !held) begin
            held <= 1'b1;
            pg_q <= pg_in;
        end
    end

    assign in_page = !held || (pg_in == pg_q);

endmodule

// File: rtl/ulk_fsm.sv
module ulk_fsm
    import wr_unlock_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stb,
    input  logic [NUM_KEYS-1:0] hit,
    input  logic                expire,
    input  logic                prog_done,
    input  logic                in_page,
    output ulk_state_t          state,
    output logic                unlocked,
    output logic                commit_en
);

    ulk_state_t nxt;
    ulk_state_t from_armed;

    // A strobe judged as the first key step.
    always_comb begin
        if (!stb)
            from_armed = ST_ARMED;
        else if (hit[0])
            from_armed = ST_KEY1;
        else
            from_armed = ST_STRAY;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_ARMED: nxt = from_armed;
            ST_KEY1: begin
                if (expire)
                    nxt = from_armed;
                else if (stb)
                    nxt = hit[1] ? ST_KEY2 : ST_STRAY;
            end
            ST_KEY2: begin
                if (expire)
                    nxt = from_armed;
                else if (stb)
                    nxt = hit[2] ? ST_OPEN : ST_STRAY;
            end
            ST_OPEN, ST_STRAY: begin
                if (expire)
                    nxt = ST_PROG;
            end
            ST_PROG: begin
                if (prog_done)
                    nxt = ST_ARMED;
            end
            default: nxt = ST_ARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_ARMED;
        else
            state <= nxt;
    end

    // Outputs.
    always_comb begin
        unlocked  = (state == ST_OPEN);
        commit_en = stb && (state == ST_OPEN) && !expire && in_page;
    end

endmodule

// File: rtl/wr_unlock_det.sv
module wr_unlock_det
    import wr_unlock_pkg::*;
#(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFS_W  = 6,
    parameter logic [NUM_KEYS*ADDR_W-1:0] KEY_ADDRS = {15'h5555, 15'h2AAA, 15'h5555},
    parameter logic [NUM_KEYS*DATA_W-1:0] KEY_DATAS = {8'hA0, 8'h55, 8'hAA}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_stb,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              win_expire,
    input  logic              prog_done,
    output logic              unlocked,
    output logic              commit_en
);

    localparam int unsigned PG_W = ADDR_W - OFS_W;

    logic [NUM_KEYS-1:0] key_hit;
    logic                in_page;
    ulk_state_t          cur_st;

    ulk_key_cmp #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NKEY     (NUM_KEYS),
        .KEY_ADDRS(KEY_ADDRS),
        .KEY_DATAS(KEY_DATAS)
    ) u_cmp (
        .addr(ld_addr),
        .data(ld_data),
        .hit (key_hit)
    );

    ulk_page_guard #(
        .PG_W(PG_W)
    ) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (cur_st != ST_OPEN),
        .take   (commit_en),
        .pg_in  (ld_addr[ADDR_W-1:OFS_W]),
        .in_page(in_page)
    );

    ulk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (ld_stb),
        .hit      (key_hit),
        .expire   (win_expire),
        .prog_done(prog_done),
        .in_page  (in_page),
        .state    (cur_st),
        .unlocked (unlocked),
        .commit_en(commit_en)
    );

endmodule

// File: rtl/wr_unlock_chk.sv
module wr_unlock_chk
    import wr_unlock_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ld_stb,
    input logic       win_expire,
    input logic       prog_done,
    input logic       unlocked,
    input logic       commit_en,
    input ulk_state_t st
);

    // R3: a byte is only committed on a strobe while unlocked
    p_commit_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> (unlocked && ld_stb));

    // R2: the load window only opens on the strobe that follows the second key
    p_open_via_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlocked) |-> ($past(ld_stb) && $past(st == ST_KEY2)));

    // R5: an expiry without a strobe between key steps returns to the first step
    p_key_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_KEY1 || st == ST_KEY2) && win_expire && !ld_stb) |=> (st == ST_ARMED));

    // R6: the window closes into the wait for the programming cycle
    p_window_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_OPEN || st == ST_STRAY) && win_expire) |=> (st == ST_PROG && !unlocked));

    // R6: the wait holds until done
    p_wait_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && !prog_done) |=> (st == ST_PROG));

    // R7: done re-arms protection
    p_rearm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && prog_done) |=> (st == ST_ARMED && !unlocked));

endmodule

bind wr_unlock_det wr_unlock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_stb    (ld_stb),
    .win_expire(win_expire),
    .prog_done (prog_done),
    .unlocked  (unlocked),
    .commit_en (commit_en),
    .st        (cur_st)
);

// File: tb/sim_wr_unlock_det.sv
`timescale 1ns/1ps
module sim_wr_unlock_det;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb = 1'b0;
    logic [14:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        win_expire = 1'b0;
    logic        prog_done = 1'b0;
    logic        unlocked;
    logic        commit_en;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    typedef struct {
        bit    xc;
        bit    xu;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    wr_unlock_det u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_stb    (ld_stb),
        .ld_addr   (ld_addr),
        .ld_data   (ld_data),
        .win_expire(win_expire),
        .prog_done (prog_done),
        .unlocked  (unlocked),
        .commit_en (commit_en)
    );

    // Driver: applies one cycle of stimulus and queues what the outputs must show in it.
    task automatic put(input bit s, input logic [14:0] a, input logic [7:0] d,
                       input bit e, input bit p, input bit xc, input bit xu,
                       input string tag);
        exp_t it;
        @(negedge clk);
        ld_stb     = s;
        ld_addr    = a;
        ld_data    = d;
        win_expire = e;
        prog_done  = p;
        it.xc  = xc;
        it.xu  = xu;
        it.tag = tag;
        q.push_back(it);
    endtask

    task automatic keys(input string tag);
        put(1, 15'h5555, 8'hAA, 0, 0, 0, 0, tag);
        put(1, 15'h2AAA, 8'h55, 0, 0, 0, 0, tag);
        put(1, 15'h5555, 8'hA0, 0, 0, 0, 0, tag);
    endtask

    // Expiry with the given unlocked state, then done; the detector is armed afterwards.
    task automatic finish_cycle(input bit xu_now, input string tag);
        put(0, 15'h0, 8'h0, 1, 0, 0, xu_now, tag);
        put(0, 15'h0, 8'h0, 0, 1, 0, 0, tag);
        put(0, 15'h0, 8'h0, 0, 0, 0, 0, tag);
    endtask

    // Monitor: pops the expected item for each cycle and compares it.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t it;
                it = q.pop_front();
                n_chk += 2;
                if (commit_en !== it.xc) begin
                    n_bad++;
                    $display("FAIL %s commit_en: actual %b expected %b", it.tag, commit_en, it.xc);
                end
                if (unlocked !== it.xu) begin
                    n_bad++;
                    $display("FAIL %s unlocked: actual %b expected %b", it.tag, unlocked, it.xu);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!fin) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs idle during reset, even with a key strobe present
        put(1, 15'h5555, 8'hAA, 0, 0, 0, 0, "R1");
        put(0, 15'h0, 8'h0, 0, 0, 0, 0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        q.push_back('{xc: 0, xu: 0, tag: "R1"});
        put(0, 15'h0, 8'h0, 0, 0, 0, 0, "R1");

        // R2 / R3: unlock, then page loads in any order with a rewrite
        keys("R2");
        put(1, 15'h0100, 8'h11, 0, 0, 1, 1, "R3");
        put(1, 15'h013F, 8'h22, 0, 0, 1, 1, "R3");
        put(1, 15'h0140, 8'h33, 0, 0, 0, 1, "R3");
        put(1, 15'h0105, 8'h44, 0, 0, 1, 1, "R3");
        put(1, 15'h0100, 8'h55, 0, 0, 1, 1, "R3");
        put(0, 15'h0, 8'h0, 0, 0, 0, 1, "R3");
        // R6: expiry closes; strobes during the wait are dropped
        put(0, 15'h0, 8'h0, 1, 0, 0, 1, "R6");
        put(1, 15'h0100, 8'h66, 0, 0, 0, 0, "R6");
        put(0, 15'h0, 8'h0, 0, 1, 0, 0, "R6");
        // R7: one-shot, a plain write after re-arm is not stored
        put(1, 15'h0100, 8'h77, 0, 0, 0, 0, "R7");
        put(1, 15'h0101, 8'h78, 0, 0, 0, 0, "R7");
        finish_cycle(0, "R7");

        // R4: wrong data at step two; a later key sequence does not rescue it
        put(1, 15'h5555, 8'hAA, 0, 0, 0, 0, "R4");
        put(1, 15'h2AAA, 8'h54, 0, 0, 0, 0, "R4");
        keys("R4");
        put(1, 15'h0200, 8'h01, 0, 0, 0, 0, "R4");
        finish_cycle(0, "R4");
        // R4: wrong address at step one
        put(1, 15'h5554, 8'hAA, 0, 0, 0, 0, "R4");
        put(1, 15'h2AAA, 8'h55, 0, 0, 0, 0, "R4");
        put(1, 15'h5555, 8'hA0, 0, 0, 0, 0, "R4");
        put(1, 15'h0200, 8'h02, 0, 0, 0, 0, "R4");
        finish_cycle(0, "R4");
        // R4: wrong data at step three
        put(1, 15'h5555, 8'hAA, 0, 0, 0, 0, "R4");
        put(1, 15'h2AAA, 8'h55, 0, 0, 0, 0, "R4");
        put(1, 15'h5555, 8'hA1, 0, 0, 0, 0, "R4");
        put(1, 15'h0200, 8'h03, 0, 0, 0, 0, "R4");
        finish_cycle(0, "R4");

        // R5: timeout in KEY2 restarts the sequence
        put(1, 15'h5555, 8'hAA, 0, 0, 0, 0, "R5");
        put(1, 15'h2AAA, 8'h55, 0, 0, 0, 0, "R5");
        put(0, 15'h0, 8'h0, 1, 0, 0, 0, "R5");
        keys("R5");
        put(1, 15'h0300, 8'h04, 0, 0, 1, 1, "R5");
        finish_cycle(1, "R5");
        // R5: expiry with a first key strobe in KEY1 counts as step one
        put(1, 15'h5555, 8'hAA, 0, 0, 0, 0, "R5");
        put(1, 15'h5555, 8'hAA, 1, 0, 0, 0, "R5");
        put(1, 15'h2AAA, 8'h55, 0, 0, 0, 0, "R5");
        put(1, 15'h5555, 8'hA0, 0, 0, 0, 0, "R5");
        put(1, 15'h0310, 8'h05, 0, 0, 1, 1, "R5");
        finish_cycle(1, "R5");

        // R8: key addresses act as ordinary locations once unlocked
        keys("R8");
        put(1, 15'h5555, 8'hAA, 0, 0, 1, 1, "R8");
        put(1, 15'h2AAA, 8'h55, 0, 0, 0, 1, "R8");
        put(1, 15'h5540, 8'hA0, 0, 0, 1, 1, "R8");
        // R6: strobe coinciding with expiry in OPEN is dropped
        put(1, 15'h5556, 8'h09, 1, 0, 0, 1, "R6");
        put(0, 15'h0, 8'h0, 0, 0, 0, 0, "R6");
        put(0, 15'h0, 8'h0, 0, 1, 0, 0, "R6");
        put(0, 15'h0, 8'h0, 0, 0, 0, 0, "R7");

        while (q.size() > 0) @(negedge clk);
        @(negedge clk);
        fin = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule